// File: doc/BRIEF.md
# Loopback Select and Collision Control for a 10/100 PHY Digital Section

This block sits between the scrambler, the descrambler and the analog transmit stage of a 10/100 Ethernet physical layer. Every symbol clock it picks the symbol stream for the descrambler input. Normally that stream is the symbol received from the line. In internal loopback it is the scrambled transmit symbol instead. The same control gates what reaches the line transmitter. In loopback the line sees no enable and an idle symbol, and the transmitter power control is dropped.

The block also produces the collision indication for the MAC. In half duplex, a collision is flagged when the MAC is transmitting and receive carrier is present. In full duplex the collision output stays low, and it also stays low in loopback. A collision test control overrides all of this: the collision output then mirrors the transmit enable.

Every output is registered. Each output therefore reflects the inputs sampled at the previous symbol clock edge. The loopback select is taken at the same edge as the symbol it steers, so a mode change never mixes two sources within one symbol.

Top module: `lbk_col_ctrl`

## Requirements
- R1: While rst_ni is low, every output (desc_sym_o, line_sym_o, line_tx_en_o, tx_pwr_on_o, col_o) is 0.
- R2: With loop_en_i low at a clock edge, desc_sym_o after that edge equals rx_sym_i sampled at that edge.
- R3: With loop_en_i high at a clock edge, desc_sym_o after that edge equals tx_sym_i sampled at that edge, whatever rx_sym_i is.
- R4: With loop_en_i high at a clock edge, after that edge line_tx_en_o is 0, line_sym_o is the idle code 0 and tx_pwr_on_o is 0, even if tx_en_i is 1.
- R5: With loop_en_i low at a clock edge, after that edge line_tx_en_o equals tx_en_i, line_sym_o equals tx_sym_i and tx_pwr_on_o is 1.
- R6: With col_test_i, loop_en_i and fdx_i all low at a clock edge, col_o after that edge equals tx_en_i AND crs_i from that edge.
- R7: With fdx_i high and col_test_i low at a clock edge, col_o after that edge is 0.
- R8: With loop_en_i high and col_test_i low at a clock edge, col_o after that edge is 0 regardless of crs_i and tx_en_i.
- R9: With col_test_i high at a clock edge, col_o after that edge equals tx_en_i from that edge, independent of loop_en_i, fdx_i and crs_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Symbol clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_sym_i | input | SYM_W | Scrambled transmit symbol |
| tx_en_i | input | 1 | Transmit enable from the MAC side |
| rx_sym_i | input | SYM_W | Symbol received from the line |
| crs_i | input | 1 | Receive carrier sense |
| loop_en_i | input | 1 | Internal loopback control |
| col_test_i | input | 1 | Collision test control |
| fdx_i | input | 1 | Full-duplex operation |
| desc_sym_o | output | SYM_W | Symbol to the descrambler input |
| line_sym_o | output | SYM_W | Symbol to the line transmitter |
| line_tx_en_o | output | 1 | Line transmitter enable |
| tx_pwr_on_o | output | 1 | Transmitter power control, 1 = powered |
| col_o | output | 1 | Collision indication |

## Verification
The only state is the output registers. A wrong value in any of them shows at the ports within one symbol clock as a wrong symbol source, a line enable leaking during loopback, or a collision flag that does not match the duplex, loopback and test combination. The bench toggles loop_en_i on consecutive symbols, so a stale or delayed select shows up as one symbol taken from the wrong source. It also walks every combination of the collision controls, so a wrong priority between collision test, loopback and duplex is exposed in the cycle right after the stimulus.

// File: rtl/lbk_pkg.sv
package lbk_pkg;

  typedef enum logic {
    SRC_LINE = 1'b0,
    SRC_LOOP = 1'b1
  } sym_src_e;

  typedef struct packed {
    logic tx_en;
    logic crs;
    logic loop_en;
    logic col_test;
    logic fdx;
  } col_ctl_t;

  // collision test overrides, then loopback and full duplex suppress
  function automatic logic col_rule(input col_ctl_t c);
    if (c.col_test) return c.tx_en;
    if (c.loop_en || c.fdx) return 1'b0;
    return c.tx_en & c.crs;
  endfunction

endpackage

// File: rtl/lbk_rx_mux.sv
module lbk_rx_mux #(
  parameter int unsigned SYM_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  lbk_pkg::sym_src_e src_i,
  input  logic [SYM_W-1:0] tx_sym_i,
  input  logic [SYM_W-1:0] rx_sym_i,
  output logic [SYM_W-1:0] sym_o
);
  import lbk_pkg::*;

  logic [SYM_W-1:0] sym_d;

  for (genvar b = 0; b < SYM_W; b++) begin : g_bit
    assign sym_d[b] = (src_i == SRC_LOOP) ? tx_sym_i[b] : rx_sym_i[b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sym_o <= '0;
    else         sym_o <= sym_d;
  end
endmodule

// File: rtl/lbk_tx_gate.sv
module lbk_tx_gate #(
  parameter int unsigned SYM_W = 5,
  parameter logic [SYM_W-1:0] IDLE_SYM = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  lbk_pkg::sym_src_e src_i,
  input  logic             tx_en_i,
  input  logic [SYM_W-1:0] tx_sym_i,
  output logic             line_en_o,
  output logic [SYM_W-1:0] line_sym_o,
  output logic             pwr_on_o
);
  import lbk_pkg::*;

  logic to_line;
  assign to_line = (src_i == SRC_LINE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_en_o  <= 1'b0;
      line_sym_o <= '0;
      pwr_on_o   <= 1'b0;
    end else begin
      line_en_o  <= to_line & tx_en_i;
      line_sym_o <= to_line ? tx_sym_i : IDLE_SYM;
      pwr_on_o   <= to_line;
    end
  end
endmodule

// File: rtl/lbk_col_gen.sv
module lbk_col_gen (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  lbk_pkg::col_ctl_t ctl_i,
  output logic              col_o
);
  import lbk_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) col_o <= 1'b0;
    else         col_o <= col_rule(ctl_i);
  end
endmodule

// File: rtl/lbk_col_ctrl.sv
module lbk_col_ctrl #(
  parameter int unsigned SYM_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SYM_W-1:0] tx_sym_i,
  input  logic             tx_en_i,
  input  logic [SYM_W-1:0] rx_sym_i,
  input  logic             crs_i,
  input  logic             loop_en_i,
  input  logic             col_test_i,
  input  logic             fdx_i,
  output logic [SYM_W-1:0] desc_sym_o,
  output logic [SYM_W-1:0] line_sym_o,
  output logic             line_tx_en_o,
  output logic             tx_pwr_on_o,
  output logic             col_o
);
  import lbk_pkg::*;

  localparam logic [SYM_W-1:0] IDLE_SYM = '0;

  sym_src_e src;
  col_ctl_t col_ctl;

  // one select per symbol edge, shared by every path
  assign src = loop_en_i ? SRC_LOOP : SRC_LINE;

  assign col_ctl = '{tx_en:    tx_en_i,
                     crs:      crs_i,
                     loop_en:  loop_en_i,
                     col_test: col_test_i,
                     fdx:      fdx_i};

  lbk_rx_mux #(.SYM_W(SYM_W)) u_rx_mux (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .src_i    (src),
    .tx_sym_i (tx_sym_i),
    .rx_sym_i (rx_sym_i),
    .sym_o    (desc_sym_o)
  );

  lbk_tx_gate #(.SYM_W(SYM_W), .IDLE_SYM(IDLE_SYM)) u_tx_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_i      (src),
    .tx_en_i    (tx_en_i),
    .tx_sym_i   (tx_sym_i),
    .line_en_o  (line_tx_en_o),
    .line_sym_o (line_sym_o),
    .pwr_on_o   (tx_pwr_on_o)
  );

  lbk_col_gen u_col_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ctl_i  (col_ctl),
    .col_o  (col_o)
  );
endmodule

// File: rtl/lbk_col_ctrl_chk.sv
module lbk_col_ctrl_chk #(
  parameter int unsigned SYM_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [SYM_W-1:0] tx_sym_i,
  input logic             tx_en_i,
  input logic [SYM_W-1:0] rx_sym_i,
  input logic             crs_i,
  input logic             loop_en_i,
  input logic             col_test_i,
  input logic             fdx_i,
  input logic [SYM_W-1:0] desc_sym_o,
  input logic [SYM_W-1:0] line_sym_o,
  input logic             line_tx_en_o,
  input logic             tx_pwr_on_o,
  input logic             col_o
);

  always_comb begin
    if (!rst_ni) begin
      assert_reset_R1: assert (desc_sym_o == '0 && line_sym_o == '0 &&
                               !line_tx_en_o && !tx_pwr_on_o && !col_o);
    end
  end

  assert_rx_path_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(loop_en_i)) |-> desc_sym_o == $past(rx_sym_i));

  assert_loop_path_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(loop_en_i)) |-> desc_sym_o == $past(tx_sym_i));

  assert_line_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(loop_en_i)) |->
      (!line_tx_en_o && line_sym_o == '0 && !tx_pwr_on_o));

  assert_line_follow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(loop_en_i)) |->
      (line_tx_en_o == $past(tx_en_i) && line_sym_o == $past(tx_sym_i) && tx_pwr_on_o));

  assert_col_half_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(col_test_i) && !$past(loop_en_i) && !$past(fdx_i)) |->
      col_o == ($past(tx_en_i) && $past(crs_i)));

  assert_col_fdx_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(fdx_i) && !$past(col_test_i)) |-> !col_o);

  assert_col_loop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(loop_en_i) && !$past(col_test_i)) |-> !col_o);

  assert_col_test_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(col_test_i)) |-> col_o == $past(tx_en_i));

endmodule

bind lbk_col_ctrl lbk_col_ctrl_chk #(.SYM_W(SYM_W)) u_chk (.*);

// File: tb/lbk_col_ctrl_bench.sv
module lbk_col_ctrl_bench;
  localparam int unsigned SYM_W = 5;

  typedef struct {
    logic [SYM_W-1:0] desc;
    logic [SYM_W-1:0] lsym;
    logic             len;
    logic             pwr;
    logic             col;
    string            tag;
  } exp_t;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [SYM_W-1:0] tx_sym_i = '0;
  logic             tx_en_i = 1'b0;
  logic [SYM_W-1:0] rx_sym_i = '0;
  logic             crs_i = 1'b0;
  logic             loop_en_i = 1'b0;
  logic             col_test_i = 1'b0;
  logic             fdx_i = 1'b0;
  logic [SYM_W-1:0] desc_sym_o;
  logic [SYM_W-1:0] line_sym_o;
  logic             line_tx_en_o;
  logic             tx_pwr_on_o;
  logic             col_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  exp_t exp_q[$];

  always #10 clk_i = ~clk_i;

  lbk_col_ctrl #(.SYM_W(SYM_W)) u_lbk_col_ctrl (.*);

  // driver: apply one symbol and queue what the outputs must be after the next edge
  task automatic drive(input logic [SYM_W-1:0] tx, input logic [SYM_W-1:0] rx,
                       input logic ten, input logic crs, input logic lp,
                       input logic ct, input logic fd, input string tag);
    exp_t e;
    @(negedge clk_i);
    tx_sym_i = tx; rx_sym_i = rx; tx_en_i = ten; crs_i = crs;
    loop_en_i = lp; col_test_i = ct; fdx_i = fd;
    e.desc = lp ? tx : rx;                 // R2 / R3
    e.lsym = lp ? '0 : tx;                 // R4 / R5
    e.len  = lp ? 1'b0 : ten;
    e.pwr  = !lp;
    if (ct)            e.col = ten;        // R9
    else if (lp || fd) e.col = 1'b0;       // R7 / R8
    else               e.col = ten & crs;  // R6
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: compare shortly after each edge
  always @(posedge clk_i) begin
    #2;
    if (rst_ni && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_chk++;
      if (desc_sym_o !== e.desc || line_sym_o !== e.lsym || line_tx_en_o !== e.len ||
          tx_pwr_on_o !== e.pwr || col_o !== e.col) begin
        n_fail++;
        $display("FAIL %s: got desc=%h lsym=%h len=%b pwr=%b col=%b exp desc=%h lsym=%h len=%b pwr=%b col=%b",
                 e.tag, desc_sym_o, line_sym_o, line_tx_en_o, tx_pwr_on_o, col_o,
                 e.desc, e.lsym, e.len, e.pwr, e.col);
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0] lfsr;
    // R1: reset state, with active inputs present
    tx_sym_i = 5'h1f; rx_sym_i = 5'h15; tx_en_i = 1'b1; crs_i = 1'b1;
    repeat (3) @(negedge clk_i);
    n_chk++;
    if (desc_sym_o !== '0 || line_sym_o !== '0 || line_tx_en_o !== 1'b0 ||
        tx_pwr_on_o !== 1'b0 || col_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: got desc=%h lsym=%h len=%b pwr=%b col=%b exp all zero",
               desc_sym_o, line_sym_o, line_tx_en_o, tx_pwr_on_o, col_o);
    end
    tx_sym_i = '0; rx_sym_i = '0; tx_en_i = 1'b0; crs_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;

    // normal path, half duplex, all tx_en/crs pairs
    drive(5'h0a, 5'h11, 0, 0, 0, 0, 0, "R2_R5_R6 idle");
    drive(5'h0b, 5'h12, 1, 0, 0, 0, 0, "R2_R5_R6 tx only");
    drive(5'h0c, 5'h13, 0, 1, 0, 0, 0, "R2_R5_R6 crs only");
    drive(5'h0d, 5'h14, 1, 1, 0, 0, 0, "R6 collision");
    // full duplex suppression
    drive(5'h0e, 5'h15, 1, 1, 0, 0, 1, "R7 fdx tx+crs");
    drive(5'h0f, 5'h16, 1, 0, 0, 0, 1, "R7 fdx tx");
    // loopback
    drive(5'h1a, 5'h05, 1, 1, 1, 0, 0, "R3_R4_R8 loop tx+crs");
    drive(5'h1b, 5'h06, 0, 1, 1, 0, 0, "R3_R4_R8 loop crs");
    drive(5'h1c, 5'h07, 1, 0, 1, 0, 1, "R3_R4_R8 loop fdx");
    // collision test over every loop/fdx/crs case
    for (int i = 0; i < 16; i++)
      drive(5'(i), 5'(~i), i[0], i[1], i[2], 1'b1, i[3], "R9 col test");
    // select toggling every symbol
    for (int i = 0; i < 8; i++)
      drive(5'(3*i+1), 5'(5*i+2), 1'b1, 1'b1, i[0], 1'b0, 1'b0, "R2_R3 toggle");
    // pseudo-random mix
    lfsr = 8'hA5;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      drive(lfsr[4:0], lfsr[7:3], lfsr[0], lfsr[2], lfsr[4], lfsr[6] & lfsr[1], lfsr[7],
            "R2_R9 mix");
    end
    repeat (3) @(negedge clk_i);
    done = 1'b1;
    finish_run();
  end
endmodule